// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port for a digital chip. It is clocked by TCK and steered by TMS. A sixteen-state controller decides when the port captures, shifts or updates data. An instruction register, loaded serially through TDI, chooses which data register sits between TDI and TDO: the one-bit bypass stage or the boundary register. The boundary register wraps a set of bidirectional chip pins.

Each pin has three boundary cells: one observes the pad input, one holds the output value, and one holds the output enable. The output and enable cells have two stages. The capture/shift stage can take in a new pattern while the update stage keeps driving the previous pattern onto the pads. The pads take the update-stage values only once Update-DR is passed.

Every TCK edge is the clock for this block. The synchronous reset `trst_n` is active low and is optional: a test host can reach the same reset state by holding TMS high.

Top module: `tap_port`

## Requirements
- R1: The controller follows the sixteen-state graph of Test-Logic-Reset, Run-Test/Idle and the DR and IR branches (select, capture, shift, exit1, pause, exit2, update). TMS is sampled on each TCK rising edge. Passing through exit1, pause and exit2 and returning to shift resumes the scan without losing or repeating a bit.
- R2: The controller enters Test-Logic-Reset after five rising edges with TMS high, from any state. It also enters it at any rising edge where `trst_n` is low. While the IR holds BYPASS, the pads carry the core's `core_out`/`core_oe`.
- R3: At every rising edge spent in Test-Logic-Reset, the instruction becomes BYPASS (all ones).
- R4: Capture-IR loads the value 0...01 into the instruction shift stage. Shifting is LSB first, so the first bit on TDO is 1 and the remaining bits are 0.
- R5: `tdo` and `tdo_oe` change only on the falling edge of TCK. `tdo_oe` is high only while the controller is in Shift-DR or Shift-IR.
- R6: When bypass is selected, Capture-DR loads 0 into the bypass stage, and TDO repeats TDI delayed by one shift.
- R7: SAMPLE (IR value 1) selects the boundary register. In Capture-DR, bit 3k takes `pad_in[k]`, bit 3k+1 takes `core_out[k]` and bit 3k+2 takes `core_oe[k]`. Bit 0 is nearest TDO. The pads keep their functional values, and `core_in` always equals `pad_in`.
- R8: EXTEST (IR value 0) selects the boundary register and drives `pad_out[k]` and `pad_oe[k]` from the update stage of bits 3k+1 and 3k+2. Changes on `core_out` and `core_oe` then have no effect on the pads.
- R9: The update stage changes only when leaving Update-DR with the boundary register selected. Through Shift-DR and Pause-DR the pads hold their previous pattern.
- R10: CLAMP (IR value 2) drives the pads from the update stage while bypass is the selected data register. A data scan under CLAMP leaves the update stage unchanged.
- R11: HIGHZ (IR value 3) forces every `pad_oe` low and selects bypass.
- R12: Any instruction value that is not 0, 1, 2 or 3 behaves as BYPASS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous test reset, active low |
| tms | input | 1 | Mode select sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Enable for the TDO driver |
| pad_in | input | NPIN | Values seen at the pads |
| core_in | output | NPIN | Pad values passed to the core |
| core_out | input | NPIN | Core's functional output values |
| core_oe | input | NPIN | Core's functional output enables |
| pad_out | output | NPIN | Values driven toward the pads |
| pad_oe | output | NPIN | Enables toward the pad drivers |

## Verification
Some properties are checked by assertions on every cycle:
- five consecutive TMS-high edges always land in Test-Logic-Reset;
- a cycle in Test-Logic-Reset always leaves BYPASS loaded;
- Capture-IR always leaves the 01 pattern in the instruction stage;
- the update stage never moves outside Update-DR;
- `tdo_oe` is never high outside a shift state.

Other behaviour only the bench's scenarios can show, because it depends on which instruction is loaded and on the data scanned:
- the order in which pin values appear on TDO;
- the one-bit bypass delay;
- a pattern surviving a pause in mid-scan;
- the pads switching to a new pattern exactly at Update-DR;
- which instruction drives, clamps or floats the pads.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
  } tap_state_t;

  typedef enum logic [2:0] {
    OP_EXTEST, OP_SAMPLE, OP_CLAMP, OP_HIGHZ, OP_BYPASS
  } tap_op_t;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    case (state)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_EX1:   nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = tms ? ST_DR_EX2   : ST_DR_PAUSE;
      ST_DR_EX2:   nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_EX1:   nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = tms ? ST_IR_EX2   : ST_IR_PAUSE;
      ST_IR_EX2:   nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end

  // run length of TMS-high edges, saturating at five (checker only)
  logic [2:0] ones_run;
  always_ff @(posedge tck) begin
    if (!trst_n || !tms)     ones_run <= 3'd0;
    else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
  end

  // R2: five rising edges with TMS high always reach Test-Logic-Reset
  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_run >= 3'd4 && tms) |=> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
#(
  parameter int IR_W = 4
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_t state,
  input  logic       tdi,
  output logic       ir_so,
  output tap_op_t    op
);

  localparam logic [IR_W-1:0] CAP_PAT  = IR_W'(1);
  localparam logic [IR_W-1:0] C_EXTEST = '0;
  localparam logic [IR_W-1:0] C_SAMPLE = IR_W'(1);
  localparam logic [IR_W-1:0] C_CLAMP  = IR_W'(2);
  localparam logic [IR_W-1:0] C_HIGHZ  = IR_W'(3);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck) begin
    if (!trst_n)                   ir_sr <= '0;
    else if (state == ST_IR_CAP)   ir_sr <= CAP_PAT;
    else if (state == ST_IR_SHIFT) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck) begin
    if (!trst_n || state == ST_RESET) ir_q <= '1;
    else if (state == ST_IR_UPD)      ir_q <= ir_sr;
  end

  always_comb begin
    if      (ir_q == C_EXTEST) op = OP_EXTEST;
    else if (ir_q == C_SAMPLE) op = OP_SAMPLE;
    else if (ir_q == C_CLAMP)  op = OP_CLAMP;
    else if (ir_q == C_HIGHZ)  op = OP_HIGHZ;
    else                       op = OP_BYPASS;
  end

  assign ir_so = ir_sr[0];

  // R3: a cycle spent in Test-Logic-Reset leaves BYPASS loaded
  a_r3_reset_bypass: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |=> (ir_q == '1));

  // R4: Capture-IR leaves 01 in the two low bits of the shift stage
  a_r4_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_IR_CAP) |=> (ir_sr[1:0] == 2'b01));

endmodule

// File: rtl/tap_bsr.sv
`timescale 1ns/1ps
module tap_bsr #(
  parameter int NPIN = 2
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            cap_en,
  input  logic            shift_en,
  input  logic            upd_en,
  input  logic            tdi,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic            so,
  output logic [NPIN-1:0] upd_out,
  output logic [NPIN-1:0] upd_oe
);

  localparam int CPP = 3;          // cells per pin: observe, data, enable
  localparam int BW  = CPP * NPIN;

  logic [BW-1:0]   sr;
  logic [BW-1:0]   par;
  logic [NPIN-1:0] sr_dat;
  logic [NPIN-1:0] sr_en;

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    assign par[CPP*k]     = pad_in[k];
    assign par[CPP*k + 1] = core_out[k];
    assign par[CPP*k + 2] = core_oe[k];
    assign sr_dat[k]      = sr[CPP*k + 1];
    assign sr_en[k]       = sr[CPP*k + 2];
  end

  // capture/shift stage: bit 0 sits next to TDO
  always_ff @(posedge tck) begin
    if (!trst_n)       sr <= '0;
    else if (cap_en)   sr <= par;
    else if (shift_en) sr <= {tdi, sr[BW-1:1]};
  end

  // update stage, only for the data and enable cells
  always_ff @(posedge tck) begin
    if (!trst_n) begin
      upd_out <= '0;
      upd_oe  <= '0;
    end else if (upd_en) begin
      upd_out <= sr_dat;
      upd_oe  <= sr_en;
    end
  end

  assign so = sr[0];

  // R9: the pad-facing stage holds whenever no update is requested
  a_r9_update_frozen: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_en |=> ($stable(upd_out) && $stable(upd_oe)));

endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
  import tap_pkg::*;
#(
  parameter int NPIN = 2,
  parameter int IR_W = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] core_in,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);

  tap_state_t      state;
  tap_op_t         op;
  logic            ir_so;
  logic            bsr_so;
  logic            bp_q;
  logic [NPIN-1:0] upd_out;
  logic [NPIN-1:0] upd_oe;

  tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  tap_ir #(.IR_W(IR_W)) u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state),
    .tdi    (tdi),
    .ir_so  (ir_so),
    .op     (op)
  );

  logic sel_bsr;
  logic drive_upd;
  logic float_pads;
  assign sel_bsr    = (op == OP_EXTEST) || (op == OP_SAMPLE);
  assign drive_upd  = (op == OP_EXTEST) || (op == OP_CLAMP);
  assign float_pads = (op == OP_HIGHZ);

  tap_bsr #(.NPIN(NPIN)) u_bsr (
    .tck      (tck),
    .trst_n   (trst_n),
    .cap_en   (sel_bsr && state == ST_DR_CAP),
    .shift_en (sel_bsr && state == ST_DR_SHIFT),
    .upd_en   (sel_bsr && state == ST_DR_UPD),
    .tdi      (tdi),
    .pad_in   (pad_in),
    .core_out (core_out),
    .core_oe  (core_oe),
    .so       (bsr_so),
    .upd_out  (upd_out),
    .upd_oe   (upd_oe)
  );

  // one-bit bypass stage
  always_ff @(posedge tck) begin
    if (!trst_n)                                  bp_q <= 1'b0;
    else if (!sel_bsr && state == ST_DR_CAP)      bp_q <= 1'b0;
    else if (!sel_bsr && state == ST_DR_SHIFT)    bp_q <= tdi;
  end

  // serial output is launched on the falling edge
  always_ff @(negedge tck) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_DR_SHIFT) || (state == ST_IR_SHIFT);
      if (state == ST_IR_SHIFT)      tdo <= ir_so;
      else if (state == ST_DR_SHIFT) tdo <= sel_bsr ? bsr_so : bp_q;
    end
  end

  assign core_in = pad_in;
  assign pad_out = drive_upd ? upd_out : core_out;
  assign pad_oe  = float_pads ? '0 : (drive_upd ? upd_oe : core_oe);

  // R5: the serial driver is only enabled while a shift state is active
  a_r5_tdo_enable: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

  // R6: the bypass stage is zero right after a capture with bypass selected
  a_r6_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (!sel_bsr && state == ST_DR_CAP) |=> (bp_q == 1'b0));

endmodule

// File: tb/sim_tap_port.sv
`timescale 1ns/1ps
module sim_tap_port;

  localparam int NPIN = 2;
  localparam int IR_W = 4;

  logic tck = 1'b0;
  always #2.5 tck = ~tck;

  logic            trst_n, tms, tdi;
  logic            tdo, tdo_oe;
  logic [NPIN-1:0] pad_in, core_in, core_out, core_oe, pad_out, pad_oe;

  tap_port #(.NPIN(NPIN), .IR_W(IR_W)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe),
    .pad_in(pad_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int n_run  = 0;
  int n_fail = 0;

  logic  eb_q[$];
  string tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: every falling edge with the serial driver on consumes one expected bit
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (tdo_oe === 1'b1) begin
        if (eb_q.size() == 0) begin
          n_run++;
          n_fail++;
          $display("FAIL R5 tdo_oe high with nothing expected actual=1 expected=0");
        end else begin
          logic  b;
          string t;
          b = eb_q.pop_front();
          t = tag_q.pop_front();
          check(t, {31'd0, tdo}, {31'd0, b});
        end
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
  endtask

  task automatic enter_dr();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(posedge tck);
    #1;
    check("R5 tdo_oe still low just after rising edge into Shift-DR", {31'd0, tdo_oe}, 32'd0);
  endtask

  task automatic enter_ir();
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(posedge tck);
    #1;
    check("R5 tdo_oe still low just after rising edge into Shift-IR", {31'd0, tdo_oe}, 32'd0);
  endtask

  // driver: queue the expected TDO bits, then shift
  task automatic shift(input logic [15:0] din, input logic [15:0] ex, input int lo,
                       input int n, input logic last, input string tag);
    for (int i = 0; i < n; i++) begin
      eb_q.push_back(ex[lo + i]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < n; i++) step(last && (i == n - 1), din[lo + i]);
  endtask

  task automatic leave();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    @(posedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [IR_W-1:0] code, input string tag);
    enter_ir();
    shift(16'(code), 16'h0001, 0, IR_W, 1'b1, tag);
    leave();
  endtask

  task automatic bypass_scan(input logic [15:0] din, input int n, input string tag);
    enter_dr();
    shift(din, din << 1, 0, n, 1'b1, tag);
    leave();
  endtask

  function automatic logic [15:0] cap_bits(input logic [NPIN-1:0] pi, input logic [NPIN-1:0] co,
                                           input logic [NPIN-1:0] ce);
    logic [15:0] r;
    r = '0;
    for (int k = 0; k < NPIN; k++) begin
      r[3*k]     = pi[k];
      r[3*k + 1] = co[k];
      r[3*k + 2] = ce[k];
    end
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge tck);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] ex;
    trst_n   = 1'b0;
    tms      = 1'b1;
    tdi      = 1'b0;
    pad_in   = 2'b01;
    core_out = 2'b10;
    core_oe  = 2'b01;
    repeat (3) @(negedge tck);
    #1 trst_n = 1'b1;
    @(posedge tck);
    #1;
    // reset state
    check("R5 reset tdo_oe", {31'd0, tdo_oe}, 32'd0);
    check("R2 reset pad_out functional", 32'(pad_out), 32'(core_out));
    check("R2 reset pad_oe functional", 32'(pad_oe), 32'(core_oe));
    check("R7 core_in follows pad_in", 32'(core_in), 32'(pad_in));
    step(1'b0, 1'b0);

    // bypass after reset
    bypass_scan(16'b101, 3, "R3 R6 R1 bypass after reset");

    // SAMPLE
    load_ir(4'b0001, "R4 capture-IR pattern (SAMPLE load)");
    check("R7 SAMPLE keeps pad_out functional", 32'(pad_out), 32'(core_out));
    pad_in = 2'b10; core_out = 2'b01; core_oe = 2'b11;
    ex = cap_bits(pad_in, core_out, core_oe);
    enter_dr();
    shift(16'b100110, ex, 0, 6, 1'b1, "R7 SAMPLE capture order");
    leave();
    check("R7 SAMPLE pad_out after update", 32'(pad_out), 32'(core_out));
    check("R7 SAMPLE pad_oe after update", 32'(pad_oe), 32'(core_oe));

    // EXTEST drives preloaded pattern
    load_ir(4'b0000, "R4 capture-IR pattern (EXTEST load)");
    check("R8 EXTEST pad_out from update stage", 32'(pad_out), 32'h1);
    check("R8 EXTEST pad_oe from update stage", 32'(pad_oe), 32'h3);
    core_out = 2'b10; core_oe = 2'b00;
    #1;
    check("R8 core_out ignored under EXTEST", 32'(pad_out), 32'h1);
    check("R8 core_oe ignored under EXTEST", 32'(pad_oe), 32'h3);

    // EXTEST scan with a pause in the middle
    ex = cap_bits(pad_in, core_out, core_oe);
    enter_dr();
    shift(16'b110000, ex, 0, 3, 1'b1, "R1 R8 EXTEST capture first half");
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(posedge tck);
    #1;
    check("R9 pads frozen in pause (out)", 32'(pad_out), 32'h1);
    check("R9 pads frozen in pause (oe)", 32'(pad_oe), 32'h3);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    shift(16'b110000, ex, 3, 3, 1'b1, "R1 R8 EXTEST capture after pause");
    check("R9 pads frozen after shift (out)", 32'(pad_out), 32'h1);
    leave();
    check("R9 pads take new pattern at update (out)", 32'(pad_out), 32'h2);
    check("R9 pads take new pattern at update (oe)", 32'(pad_oe), 32'h2);

    // CLAMP
    load_ir(4'b0010, "R4 capture-IR pattern (CLAMP load)");
    check("R10 CLAMP pad_out", 32'(pad_out), 32'h2);
    check("R10 CLAMP pad_oe", 32'(pad_oe), 32'h2);
    bypass_scan(16'b011, 3, "R10 CLAMP selects bypass");
    check("R10 CLAMP scan leaves update stage", 32'(pad_out), 32'h2);

    // HIGHZ
    load_ir(4'b0011, "R4 capture-IR pattern (HIGHZ load)");
    check("R11 HIGHZ pad_oe low", 32'(pad_oe), 32'h0);
    core_oe = 2'b11;
    #1;
    check("R11 HIGHZ ignores core_oe", 32'(pad_oe), 32'h0);
    bypass_scan(16'b01, 2, "R11 HIGHZ selects bypass");

    // unrecognised code
    load_ir(4'b0101, "R4 capture-IR pattern (code 5 load)");
    check("R12 unknown code pad_out functional", 32'(pad_out), 32'(core_out));
    check("R12 unknown code pad_oe functional", 32'(pad_oe), 32'(core_oe));
    bypass_scan(16'b10, 2, "R12 unknown code acts as bypass");

    // five TMS-high edges from inside Shift-IR
    load_ir(4'b0000, "R4 capture-IR pattern (EXTEST reload)");
    core_out = 2'b01;
    #1;
    check("R8 EXTEST reload pad_out", 32'(pad_out), 32'h2);
    enter_ir();
    eb_q.push_back(1'b1);
    tag_q.push_back("R4 first IR bit before reset walk");
    repeat (5) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    @(posedge tck);
    #1;
    check("R2 five TMS-high edges restore functional pads", 32'(pad_out), 32'(core_out));
    step(1'b0, 1'b0);
    bypass_scan(16'b1, 1, "R3 BYPASS after TMS reset walk");

    // synchronous trst_n
    load_ir(4'b0000, "R4 capture-IR pattern (before trst_n)");
    check("R8 EXTEST before trst_n", 32'(pad_out), 32'h2);
    @(negedge tck);
    #1;
    trst_n = 1'b0;
    tms = 1'b0;
    @(negedge tck);
    #1;
    trst_n = 1'b1;
    check("R2 trst_n restores functional pads", 32'(pad_out), 32'(core_out));
    step(1'b0, 1'b0);
    bypass_scan(16'b11, 2, "R3 BYPASS after trst_n");

    repeat (3) @(posedge tck);
    #1;
    check("R1 all expected TDO bits consumed", 32'(eb_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule